// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a simple host request port and a single-bit multiplexed-address DRAM. A host request carries a 22-bit word address, a write flag and one data bit. The controller splits the address into a row half and a column half and sends them one after the other on a shared 11-bit address bus. It sequences the active-low row strobe, column strobe and write-enable so that rows are opened, columns are accessed and rows are precharged with cycle counts taken from parameters.

Once a row is open, the controller keeps it open. A later request to the same row needs only a new column address and a CAS pulse. A request to a different row closes the row, waits the precharge count and then opens the new row. The row is also closed when the remaining RAS-low budget cannot fit another column access. Writes are always early writes: W is low a full cycle before CAS falls. Read data is sampled at the end of the CAS-low window and returned as a one-cycle pulse.

The request port uses valid/ready. The host must hold `req_valid`, `req_we`, `req_addr` and `req_wdata` steady until a clock edge where `req_valid` and `req_ready` are both high; that edge transfers the request. `req_ready` depends only on the controller state, never on `req_valid`. The response side cannot apply back-pressure: each read produces exactly one `rsp_valid` pulse, in request order. The parameters must satisfy T_RAS_MAX >= T_RCD + 2*(2 + T_CAS + T_CP) + 2 so that at least one access fits in each row-open period.

Top module: `dram_page_ctrl`

## Requirements
- R1: Reset state and idle state. Out of reset, and whenever no row is open, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are all 1 and `req_ready` is 1.
- R2: Address split. The row is `req_addr[21:11]` and appears on `dram_a` when RAS falls. The column is `req_addr[10:0]` and appears on `dram_a` when CAS falls.
- R3: Address stability. `dram_a` holds the same value in the cycle before and the cycle in which RAS falls. The same rule holds for CAS.
- R4: Write selection. A write (`req_we`=1) drives `dram_we_n`=0, and W is already 0 in the cycle before CAS falls (early write). `dram_d` carries the write bit while CAS is low. A read keeps `dram_we_n`=1.
- R5: Read return. A read samples `dram_q` in the last CAS-low cycle and raises `rsp_valid` for exactly one cycle with that bit on `rsp_rdata`. Read responses come back in request order, and writes produce no response.
- R6: Page hits. While the row is open, requests to the same row are served with CAS pulses only, with no new RAS falling edge. CAS is only ever low while RAS is low.
- R7: Row miss. A request to a different row makes RAS go high for at least T_RP cycles before RAS falls for the new row.
- R8: RAS budget. RAS never stays low for more than T_RAS_MAX consecutive cycles. A long run of same-row hits is split across several row openings.
- R9: Back-pressure. `req_ready` is 0 while an access is in progress, including every cycle in which CAS is low. Every request held by the host is transferred exactly once.
- R10: CAS precharge. Between two CAS-low pulses, CAS stays high for at least T_CP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_wdata | input | 1 | Write data bit |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 1 | Read data bit |
| dram_a | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_d | output | 1 | Data toward the DRAM |
| dram_q | input | 1 | Data from the DRAM |

## Verification
The bench attaches a behavioural DRAM. The DRAM latches the row and column on the strobe edges and checks each latched pair against the address the host sent. A wrong split or a bus that changes at a strobe edge would therefore show up as a mismatch or as corrupted read data. Bursts to one row test page hits: a controller that reopened the row on a hit would show extra RAS falls, and one that ignored the row compare on a miss would read the wrong row. A 20-access same-row burst tests the RAS budget: a controller that never closed the row would exceed the RAS-low limit. Late-W writes and a too-short precharge or CAS-high gap are caught at the DRAM pins.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RSET = 3'd1,
    S_RAS  = 3'd2,
    S_CSET = 3'd3,
    S_CAS  = 3'd4,
    S_CP   = 3'd5,
    S_OPEN = 3'd6,
    S_PRE  = 3'd7
  } dpm_state_t;
endpackage

// File: rtl/dpm_row_track.sv
module dpm_row_track #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             close,
  input  logic [ROW_W-1:0] load_row,
  input  logic [ROW_W-1:0] probe_row,
  output logic             hit
);
  logic [ROW_W-1:0] open_row;
  logic             open_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_row <= '0;
      open_v   <= 1'b0;
    end else if (close) begin
      open_v <= 1'b0;
    end else if (load) begin
      open_row <= load_row;
      open_v   <= 1'b1;
    end
  end

  assign hit = open_v && (open_row == probe_row);

  // R6: a row cannot be loaded and closed in the same cycle
  p_load_close_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && close));
endmodule

// File: rtl/dpm_ras_budget.sv
module dpm_ras_budget #(
  parameter int T_RAS_MAX = 40,
  parameter int PAGE_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic page_ok
);
  localparam int RW    = $clog2(T_RAS_MAX + 1) + 1;
  localparam int LIMIT = T_RAS_MAX - 2 - PAGE_CYC;

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)       run <= '0;
    else if (!ras_low) run <= '0;
    else if (run < RW'(T_RAS_MAX)) run <= run + 1'b1;
  end

  assign page_ok = (run <= RW'(LIMIT));
endmodule

// File: rtl/dpm_seq.sv
module dpm_seq
  import dpm_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int T_RCD = 3,
  parameter int T_CAS = 2,
  parameter int T_CP  = 1,
  parameter int T_RP  = 3,
  parameter int CW    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_wdata,
  input  logic                   hit,
  input  logic                   page_ok,
  output logic                   load_row,
  output logic                   close_row,
  output logic [ROW_W-1:0]       row_out,
  output logic                   ras_low,
  output logic                   rsp_valid,
  output logic                   rsp_rdata,
  output logic [ROW_W-1:0]       dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_d,
  input  logic                   dram_q
);
  localparam int AW = ROW_W + COL_W;

  dpm_state_t       st;
  logic [CW-1:0]    cnt;
  logic             we_q, d_q, pend;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             take;

  assign take = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      we_q      <= 1'b0;
      d_q       <= 1'b0;
      pend      <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (take) begin
        we_q  <= req_we;
        d_q   <= req_wdata;
        row_q <= req_addr[AW-1:COL_W];
        col_q <= req_addr[COL_W-1:0];
      end
      case (st)
        S_IDLE: if (take) st <= S_RSET;
        S_RSET: begin
          st  <= S_RAS;
          cnt <= CW'(T_RCD - 1);
        end
        S_RAS: begin
          if (cnt == '0) st <= S_CSET;
          else cnt <= cnt - 1'b1;
        end
        S_CSET: begin
          st  <= S_CAS;
          cnt <= CW'(T_CAS - 1);
        end
        S_CAS: begin
          if (cnt == '0) begin
            if (!we_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_q;
            end
            st  <= S_CP;
            cnt <= CW'(T_CP - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_CP: begin
          if (cnt == '0) st <= S_OPEN;
          else cnt <= cnt - 1'b1;
        end
        S_OPEN: begin
          if (!page_ok) begin
            st   <= S_PRE;
            cnt  <= CW'(T_RP - 1);
            pend <= 1'b0;
          end else if (req_valid) begin
            if (hit) st <= S_CSET;
            else begin
              st   <= S_PRE;
              cnt  <= CW'(T_RP - 1);
              pend <= 1'b1;
            end
          end
        end
        S_PRE: begin
          if (cnt == '0) begin
            st   <= pend ? S_RSET : S_IDLE;
            pend <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ras_low   = (st == S_RAS) || (st == S_CSET) || (st == S_CAS) ||
                (st == S_CP) || (st == S_OPEN);
    req_ready = (st == S_IDLE) || ((st == S_OPEN) && page_ok);
    load_row  = (st == S_RSET);
    close_row = (st == S_PRE);
    row_out   = row_q;
    dram_ras_n = !ras_low;
    dram_cas_n = !(st == S_CAS);
    dram_we_n  = !(((st == S_CSET) || (st == S_CAS)) && we_q);
    dram_d     = d_q;
    if ((st == S_RSET) || (st == S_RAS) || (st == S_PRE)) dram_a = row_q;
    else if (st == S_IDLE)                                dram_a = '0;
    else                                                  dram_a = ROW_W'(col_q);
  end

  // R3: address bus holds across strobe edges
  p_row_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_a));
  p_col_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_a));
  // R4: write enable low one cycle before CAS falls
  p_early_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> !$past(dram_we_n));
  // R6: CAS only inside an open row
  p_cas_in_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  // R5: response is a single-cycle pulse
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9: no request taken while CAS is low
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !req_ready);
  // R1: ready with RAS high means all strobes idle
  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && dram_ras_n) |-> (dram_cas_n && dram_we_n));
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_rdata,
  output logic [ROW_W-1:0]       dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_d,
  input  logic                   dram_q
);
  localparam int AW       = ROW_W + COL_W;
  localparam int PAGE_CYC = 2 + T_CAS + T_CP;
  localparam int CW       = $clog2(T_RCD + T_CAS + T_CP + T_RP + 1) + 1;
  localparam int LW       = $clog2(T_RAS_MAX + 2) + 1;
  localparam int HW       = $clog2(T_RP + T_CP + 2) + 1;

  logic             hit, page_ok, load_row, close_row, ras_low;
  logic [ROW_W-1:0] row_out;

  dpm_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .load(load_row), .close(close_row),
    .load_row(row_out), .probe_row(req_addr[AW-1:COL_W]), .hit(hit));

  dpm_ras_budget #(.T_RAS_MAX(T_RAS_MAX), .PAGE_CYC(PAGE_CYC)) u_budget (
    .clk(clk), .rst_n(rst_n), .ras_low(ras_low), .page_ok(page_ok));

  dpm_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_RP(T_RP), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .hit(hit), .page_ok(page_ok), .load_row(load_row), .close_row(close_row),
    .row_out(row_out), .ras_low(ras_low), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_d(dram_d),
    .dram_q(dram_q));

  // Pin-level run counters kept apart from the budget logic
  logic [LW-1:0] lo_run;
  logic [HW-1:0] hi_run, cas_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= HW'(T_RP);
      cas_hi <= HW'(T_CP);
    end else begin
      if (dram_ras_n) lo_run <= '0;
      else if (lo_run <= LW'(T_RAS_MAX)) lo_run <= lo_run + 1'b1;
      if (!dram_ras_n) hi_run <= '0;
      else if (hi_run < HW'(T_RP + 1)) hi_run <= hi_run + 1'b1;
      if (!dram_cas_n) cas_hi <= '0;
      else if (cas_hi < HW'(T_CP + 1)) cas_hi <= cas_hi + 1'b1;
    end
  end

  // R8: RAS-low run bounded
  p_ras_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (lo_run < LW'(T_RAS_MAX)));
  // R7: precharge length before every row open
  p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_run >= HW'(T_RP)));
  // R10: CAS high gap
  p_cas_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (cas_hi >= HW'(T_CP)));
endmodule

// File: tb/tb_dram_page_ctrl.sv
module tb_dram_page_ctrl;
  localparam int ROW_W = 11, COL_W = 11, AW = 22;
  localparam int T_RCD = 3, T_CAS = 2, T_CP = 1, T_RP = 3, T_RAS_MAX = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata;
  logic [ROW_W-1:0] dram_a;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_d;
  logic dram_q = 1'b0;

  always #4 clk = ~clk;

  dram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_d(dram_d), .dram_q(dram_q));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference contents and scoreboard queues
  bit ref_mem [int];
  bit exp_q [$];
  int addr_q [$];

  // Behavioural DRAM
  bit dram_mem [int];
  logic [ROW_W-1:0] lat_row;
  logic p_ras = 1, p_cas = 1, p_we = 1;
  logic [ROW_W-1:0] p_a = '0;
  int ras_falls = 0, lo_cnt = 0, max_lo = 0, hi_cnt = 100, cas_hi = 100;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_ras_n && p_ras) begin
        ras_falls++;
        lat_row = dram_a;
        chk(dram_a == p_a, "R3 row stable", dram_a, p_a);
        chk(hi_cnt >= T_RP, "R7 precharge", hi_cnt, T_RP);
      end
      if (!dram_cas_n && p_cas) begin
        int a;
        a = int'({lat_row, dram_a});
        chk(dram_a == p_a, "R3 col stable", dram_a, p_a);
        chk(!dram_ras_n, "R6 cas inside ras", dram_ras_n, 0);
        chk(cas_hi >= T_CP, "R10 cas gap", cas_hi, T_CP);
        chk(!req_ready, "R9 busy during cas", req_ready, 0);
        if (addr_q.size() > 0) begin
          int e;
          e = addr_q.pop_front();
          chk(a == e, "R2 address split", a, e);
        end else chk(0, "R2 unexpected cas", a, -1);
        if (!dram_we_n) begin
          chk(!p_we, "R4 early write", p_we, 0);
          dram_mem[a] = dram_d;
        end else dram_q = dram_mem.exists(a) ? dram_mem[a] : 1'b0;
      end
      if (dram_cas_n && !p_cas) dram_q = 1'b0;
      if (!dram_ras_n) begin
        lo_cnt++;
        if (lo_cnt > max_lo) max_lo = lo_cnt;
        hi_cnt = 0;
      end else begin
        lo_cnt = 0;
        hi_cnt++;
      end
      cas_hi = dram_cas_n ? cas_hi + 1 : 0;
    end
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_a = dram_a;
  end

  // Response monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 response without read", rsp_rdata, -1);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R5 read data", rsp_rdata, e);
      end
    end
  end

  task automatic send(input bit we, input int row, input int col, input bit d);
    int a;
    a = (row << COL_W) | col;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    addr_q.push_back(a);
    if (we) ref_mem[a] = d;
    else exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 1'b0);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic drain;
    int guard;
    guard = 0;
    while ((exp_q.size() > 0 || addr_q.size() > 0) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 reset strobes", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(req_ready, "R1 reset ready", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && dram_ras_n, "R1 idle after reset", {req_ready, dram_ras_n}, 3);

    // Writes over several rows, then read back (R2 R4 R5)
    send(1, 5, 3, 1);
    send(1, 5, 9, 1);
    send(1, 5, 10, 0);
    send(1, 700, 2047, 1);
    send(1, 2047, 0, 1);
    send(1, 0, 0, 0);
    send(0, 5, 3, 0);
    send(0, 2047, 0, 0);
    send(0, 5, 9, 0);
    send(0, 5, 10, 0);
    send(0, 700, 2047, 0);
    send(0, 0, 0, 0);
    send(0, 9, 9, 0);
    send(1, 300, 1, 1);
    send(0, 300, 1, 0);
    send(1, 300, 1, 0);
    send(0, 300, 1, 0);
    drain();

    // Page hits: one RAS fall for four same-row reads (R6)
    send(0, 5, 3, 0);
    drain();
    f0 = ras_falls;
    send(0, 100, 0, 0);
    send(0, 100, 1, 0);
    send(0, 100, 2, 0);
    send(0, 100, 3, 0);
    drain();
    chk(ras_falls - f0 == 1, "R6 page hits share one RAS", ras_falls - f0, 1);

    // Row miss re-opens (R7)
    f0 = ras_falls;
    send(0, 101, 0, 0);
    drain();
    chk(ras_falls - f0 == 1, "R7 miss opens new row", ras_falls - f0, 1);

    // Long same-row burst split by budget (R8)
    f0 = ras_falls;
    for (int i = 0; i < 20; i++) send(0, 101, i, 0);
    drain();
    chk(ras_falls - f0 >= 3, "R8 burst split", ras_falls - f0, 3);
    chk(max_lo <= T_RAS_MAX, "R8 RAS low bound", max_lo, T_RAS_MAX);

    // Idle closes row and returns strobes high (R1)
    repeat (80) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && req_ready, "R1 idle strobes",
        {dram_ras_n, dram_cas_n, dram_we_n, req_ready}, 15);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule